// File: doc/BRIEF.md
# Half-Duplex Shared-Medium Transmit Gate

This block decides when a MAC transmitter may put a frame onto a shared half-duplex medium. The requester raises `frame_req` and holds it. If the medium is busy, the controller waits. When the carrier goes idle, it waits a further pseudo-random number of cycles and then raises `tx_grant`. While the grant is up, a collision ends the attempt at once. The controller then asks for a jam sequence for a fixed number of cycles. After the jam it waits a random number of slot times, and the range of that wait doubles with each collision up to a cap. Then it contends again. A frame that collides too many times is dropped, and a one-cycle abort pulse reports it. In full-duplex mode there is no contention: the grant follows the request after one cycle, and both the carrier and the collision inputs are ignored.

All pins are plain control and status signals. There is no data path and no stream handshake. The request protocol is simple. `frame_req` stays high until the cycle in which `tx_done` or `abort_excess` is seen, and is dropped in that cycle. `frame_end` is raised for one cycle while `tx_grant` is high, to say that the last bit has gone out. A free-running LFSR that steps on every clock supplies both random draws. Because it keeps stepping, the value drawn depends on how long the medium stayed busy.

Top module: `csma_tx_ctrl`

## Requirements
- R1: In half-duplex mode, `tx_grant` never rises in the cycle after one in which `carrier_sense` was high.
- R2: In half-duplex mode with the carrier idle, the grant appears between 2 and 2^WAIT_BITS+1 cycles after the first idle cycle. The delay is a random value from 0 to 2^WAIT_BITS−1, plus two cycles.
- R3: A collision seen while `tx_grant` is high in half-duplex mode drops `tx_grant` and raises `jam_req` on the next cycle.
- R4: `jam_req` stays high for exactly JAM_CYCLES consecutive cycles.
- R5: After the n-th collision of a frame, the controller backs off r·SLOT_CYCLES cycles, with r random in 0 to 2^min(n,BACKOFF_LIMIT)−1. The gap from the end of the jam to the next grant therefore lies between 3 and (2^min(n,BACKOFF_LIMIT)−1)·SLOT_CYCLES + 2^WAIT_BITS + 2 cycles. Successive gaps are not all equal.
- R6: In the last jam cycle of the MAX_ATTEMPTS-th collision, `abort_excess` is high for one cycle. The frame is then dropped and no further grant follows.
- R7: In full-duplex mode, `tx_grant` rises one cycle after `frame_req`, even with the carrier busy. A collision during the grant causes no jam.
- R8: `frame_end` while granted, with no collision counted, gives a one-cycle `tx_done` in the same cycle. The grant is low on the next cycle.
- R9: After reset, `tx_grant`, `jam_req`, `tx_done` and `abort_excess` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_req | input | 1 | A frame is waiting; held until done or abort |
| frame_end | input | 1 | Last bit of the frame sent (valid while granted) |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision detected on the medium |
| full_duplex | input | 1 | 1 = full duplex, no contention |
| tx_grant | output | 1 | Transmitter may drive the medium |
| jam_req | output | 1 | Send the jam pattern now |
| tx_done | output | 1 | One-cycle pulse: frame sent |
| abort_excess | output | 1 | One-cycle pulse: too many collisions, frame dropped |

## Verification
The cycle-level rules hold on every cycle, and the bound checker watches them throughout the run. These are: no grant start after a busy carrier cycle, a jam that starts right after a half-duplex collision, the exact jam length, grant and jam never high together, and single-cycle abort and done pulses. The random parts can only be shown by the bench's scenarios. Those are the bounded wait after idle, the backoff range that widens with the collision count, and the variation between successive retry gaps. So are the whole sequence up to the excessive-collision abort and the full-duplex bypass.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_WAIT,
    ST_TX,
    ST_JAM,
    ST_BACKOFF
  } tx_state_e;
endpackage

// File: rtl/csma_lfsr.sv
// Free-running Galois LFSR; steps every clock.
module csma_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'h5A3C
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] r;

  always_ff @(posedge clk) begin
    if (!rst_n) r <= SEED;
    else if (r[0]) r <= (r >> 1) ^ TAPS;
    else r <= r >> 1;
  end

  assign value = r;
endmodule

// File: rtl/csma_backoff_timer.sv
// Counts a number of slots, each SLOT_CYCLES long; expire is high in the last cycle.
module csma_backoff_timer #(
  parameter int SLOT_CYCLES = 512,
  parameter int SLOT_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] slots_in,
  output logic              expire
);
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] CYC_LOAD = CW'(SLOT_CYCLES - 1);

  logic              active;
  logic [SLOT_W-1:0] slots;
  logic [CW-1:0]     cyc;

  assign expire = active && (cyc == '0) && (slots == SLOT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      slots  <= '0;
      cyc    <= '0;
    end else if (start) begin
      active <= (slots_in != '0);
      slots  <= slots_in;
      cyc    <= CYC_LOAD;
    end else if (active) begin
      if (cyc == '0) begin
        if (slots == SLOT_W'(1)) active <= 1'b0;
        else begin
          slots <= slots - SLOT_W'(1);
          cyc   <= CYC_LOAD;
        end
      end else begin
        cyc <= cyc - CW'(1);
      end
    end
  end
endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl #(
  parameter int                SLOT_CYCLES   = 512,
  parameter int                JAM_CYCLES    = 32,
  parameter int                WAIT_BITS     = 4,
  parameter int                MAX_ATTEMPTS  = 16,
  parameter int                BACKOFF_LIMIT = 10,
  parameter int                LFSR_W        = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS     = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED     = 16'h5A3C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_req,
  input  logic frame_end,
  input  logic carrier_sense,
  input  logic collision,
  input  logic full_duplex,
  output logic tx_grant,
  output logic jam_req,
  output logic tx_done,
  output logic abort_excess
);
  import csma_pkg::*;

  localparam int WAIT_MAX = (1 << WAIT_BITS) - 1;
  localparam int CNT_MAX  = (JAM_CYCLES - 1 > WAIT_MAX) ? JAM_CYCLES - 1 : WAIT_MAX;
  localparam int CW       = (CNT_MAX > 1) ? $clog2(CNT_MAX + 1) : 1;
  localparam int ATT_W    = $clog2(MAX_ATTEMPTS + 1);

  tx_state_e            state, state_nx;
  logic [CW-1:0]        cnt;
  logic [ATT_W-1:0]     attempts;
  logic [LFSR_W-1:0]    rnd;
  logic [BACKOFF_LIMIT-1:0] bo_mask, bo_slots;
  logic                 coll_hit, jam_last, bo_start, bo_expire;

  csma_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .value(rnd)
  );

  // Range mask: min(attempts, BACKOFF_LIMIT) low bits set.
  always_comb begin
    for (int i = 0; i < BACKOFF_LIMIT; i++)
      bo_mask[i] = (ATT_W'(i) < attempts);
  end

  assign bo_slots  = rnd[LFSR_W-1 -: BACKOFF_LIMIT] & bo_mask;
  assign coll_hit  = (state == ST_TX) && collision && !full_duplex;
  assign jam_last  = (state == ST_JAM) && (cnt == '0);
  assign abort_excess = jam_last && (attempts == ATT_W'(MAX_ATTEMPTS));
  assign bo_start  = jam_last && !abort_excess;

  csma_backoff_timer #(.SLOT_CYCLES(SLOT_CYCLES), .SLOT_W(BACKOFF_LIMIT)) u_backoff (
    .clk(clk), .rst_n(rst_n), .start(bo_start), .slots_in(bo_slots), .expire(bo_expire)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (frame_req) state_nx = full_duplex ? ST_TX : ST_DEFER;
      ST_DEFER:   if (full_duplex) state_nx = ST_TX;
                  else if (!carrier_sense) state_nx = ST_WAIT;
      ST_WAIT:    if (full_duplex) state_nx = ST_TX;
                  else if (carrier_sense) state_nx = ST_DEFER;
                  else if (cnt == '0) state_nx = ST_TX;
      ST_TX:      if (coll_hit) state_nx = ST_JAM;
                  else if (frame_end) state_nx = ST_IDLE;
      ST_JAM:     if (jam_last) begin
                    if (abort_excess) state_nx = ST_IDLE;
                    else if (bo_slots == '0) state_nx = ST_DEFER;
                    else state_nx = ST_BACKOFF;
                  end
      ST_BACKOFF: if (bo_expire) state_nx = ST_DEFER;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      attempts <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE) attempts <= '0;
      else if (coll_hit) attempts <= attempts + ATT_W'(1);
      if (coll_hit) cnt <= CW'(JAM_CYCLES - 1);
      else if (state_nx == ST_WAIT && state != ST_WAIT) cnt <= CW'(rnd[WAIT_BITS-1:0]);
      else if ((state == ST_WAIT || state == ST_JAM) && cnt != '0) cnt <= cnt - CW'(1);
    end
  end

  assign tx_grant = (state == ST_TX);
  assign jam_req  = (state == ST_JAM);
  assign tx_done  = (state == ST_TX) && frame_end && !coll_hit;
endmodule

// File: rtl/csma_tx_ctrl_chk.sv
module csma_tx_ctrl_chk #(
  parameter int JAM_CYCLES = 32
) (
  input logic clk,
  input logic rst_n,
  input logic carrier_sense,
  input logic collision,
  input logic full_duplex,
  input logic tx_grant,
  input logic jam_req,
  input logic tx_done,
  input logic abort_excess
);
  localparam int JW = $clog2(JAM_CYCLES + 1);
  logic [JW-1:0] jcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !jam_req) jcnt <= '0;
    else jcnt <= jcnt + JW'(1);
  end

  a_r1_no_start_on_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_grant) && !$past(full_duplex)) |-> !$past(carrier_sense));

  a_r3_collision_jams: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_grant && collision && !full_duplex) |=> (jam_req && !tx_grant));

  a_r4_jam_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam_req) |-> (jcnt == JW'(JAM_CYCLES)));

  a_r4_jam_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    jam_req |-> (jcnt < JW'(JAM_CYCLES)));

  a_r3_grant_jam_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_grant && jam_req));

  a_r6_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_excess |=> (!abort_excess && !tx_grant));

  a_r7_fd_no_jam: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_grant && full_duplex) |=> !jam_req);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (!tx_done && !tx_grant));
endmodule

bind csma_tx_ctrl csma_tx_ctrl_chk #(.JAM_CYCLES(JAM_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .carrier_sense(carrier_sense), .collision(collision),
  .full_duplex(full_duplex), .tx_grant(tx_grant), .jam_req(jam_req),
  .tx_done(tx_done), .abort_excess(abort_excess)
);

// File: tb/test_csma_tx_ctrl.sv
`timescale 1ns/1ps
module test_csma_tx_ctrl;
  localparam int SLOT = 2;
  localparam int JAM  = 4;
  localparam int WB   = 3;
  localparam int MAXA = 16;
  localparam int BL   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_req = 0, frame_end = 0, carrier_sense = 0, collision = 0, full_duplex = 0;
  logic tx_grant, jam_req, tx_done, abort_excess;

  int checks = 0, errors = 0;
  bit finished = 0;
  int first_gap = -1;
  bit gaps_differ = 0;

  always #4 clk = ~clk;

  csma_tx_ctrl #(.SLOT_CYCLES(SLOT), .JAM_CYCLES(JAM), .WAIT_BITS(WB),
                 .MAX_ATTEMPTS(MAXA), .BACKOFF_LIMIT(BL)) i_csma_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .frame_end(frame_end),
    .carrier_sense(carrier_sense), .collision(collision), .full_duplex(full_duplex),
    .tx_grant(tx_grant), .jam_req(jam_req), .tx_done(tx_done), .abort_excess(abort_excess)
  );

  function automatic int max_idle_wait();
    return (1 << WB) + 1;
  endfunction

  function automatic int max_retry_gap(int n);
    int e = (n < BL) ? n : BL;
    return ((1 << e) - 1) * SLOT + (1 << WB) + 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Samples at negedges until grant; n = cycles counted; checks R1 while carrier high.
  task automatic wait_grant(int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (carrier_sense && !full_duplex && tx_grant)
        chk(0, "R1 grant while carrier busy", 1, 0);
    end while (!tx_grant && n < limit);
  endtask

  task automatic finish_frame();
    int hold = $urandom_range(0, 3);
    repeat (hold) @(negedge clk);
    frame_end = 1;
    #1;
    chk(tx_done == 1'b1, "R8 done pulse", int'(tx_done), 1);
    @(negedge clk);
    frame_end = 0;
    frame_req = 0;
    chk(tx_grant == 1'b0 && tx_done == 1'b0, "R8 grant released", int'(tx_grant), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({tx_grant, jam_req, tx_done, abort_excess} == 4'b0, "R9 reset outputs",
        int'({tx_grant, jam_req, tx_done, abort_excess}), 0);
    rst_n = 1;
    @(negedge clk);
    chk({tx_grant, jam_req, tx_done, abort_excess} == 4'b0, "R9 idle after reset",
        int'({tx_grant, jam_req, tx_done, abort_excess}), 0);

    // Deferral and random wait (R1, R2, R8)
    for (int it = 0; it < 6; it++) begin
      int busy = $urandom_range(1, 12);
      int n;
      carrier_sense = 1;
      frame_req = 1;
      for (int b = 0; b < busy; b++) begin
        @(negedge clk);
        chk(tx_grant == 1'b0, "R1 no grant while busy", int'(tx_grant), 0);
      end
      carrier_sense = 0;
      wait_grant(200, n);
      chk(n >= 2 && n <= max_idle_wait(), "R2 wait after idle", n, max_idle_wait());
      finish_frame();
      repeat ($urandom_range(1, 4)) @(negedge clk);
    end

    // Collisions and backoff (R3, R4, R5)
    for (int it = 0; it < 4; it++) begin
      int ncoll = $urandom_range(1, 3);
      int n;
      frame_req = 1;
      wait_grant(200, n);
      for (int c = 1; c <= ncoll; c++) begin
        int jl, m;
        collision = 1;
        @(negedge clk);
        chk(jam_req == 1'b1 && tx_grant == 1'b0, "R3 jam after collision", int'(jam_req), 1);
        collision = 0;
        jl = 1;
        m = 0;
        forever begin
          @(negedge clk);
          if (jam_req) jl++;
          else break;
        end
        chk(jl == JAM, "R4 jam length", jl, JAM);
        m = 1;
        while (!tx_grant && m < 20000) begin
          @(negedge clk);
          m++;
        end
        chk(m >= 3 && m <= max_retry_gap(c), "R5 retry gap bound", m, max_retry_gap(c));
        if (first_gap < 0) first_gap = m;
        else if (m != first_gap) gaps_differ = 1;
      end
      finish_frame();
      repeat (2) @(negedge clk);
    end
    chk(gaps_differ, "R5 retry gaps vary", int'(gaps_differ), 1);

    // Full duplex bypass (R7)
    full_duplex = 1;
    carrier_sense = 1;
    collision = 1;
    frame_req = 1;
    @(negedge clk);
    chk(tx_grant == 1'b1, "R7 immediate grant", int'(tx_grant), 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(tx_grant == 1'b1 && jam_req == 1'b0, "R7 collision ignored", int'(jam_req), 0);
    end
    finish_frame();
    full_duplex = 0;
    carrier_sense = 0;
    collision = 0;
    repeat (2) @(negedge clk);

    // Excessive collisions (R6)
    begin
      int jams = 0;
      int guard = 0;
      bit prev_jam = 0;
      bit got_abort = 0;
      collision = 1;
      frame_req = 1;
      while (!got_abort && guard < 100000) begin
        @(negedge clk);
        guard++;
        if (jam_req && !prev_jam) jams++;
        prev_jam = jam_req;
        if (abort_excess) begin
          got_abort = 1;
          frame_req = 0;
        end
      end
      chk(got_abort, "R6 abort raised", int'(got_abort), 1);
      chk(jams == MAXA, "R6 attempts before abort", jams, MAXA);
      @(negedge clk);
      chk(abort_excess == 1'b0, "R6 abort single cycle", int'(abort_excess), 0);
      begin
        bit any = 0;
        for (int k = 0; k < 20; k++) begin
          @(negedge clk);
          if (tx_grant || jam_req) any = 1;
        end
        chk(!any, "R6 frame dropped", int'(any), 0);
      end
      collision = 0;
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule